// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block merges the interrupt summary lines of several GPIO banks with a set of other peripheral request lines into one pending-status word and drives a single interrupt request toward the host processor. GPIO bank summaries take the low bits of the word and the peripheral requests follow above them in ascending order. Both kinds of input are followed as levels; a bank summary clears only when the bank itself clears it.

A small register port exposes two registers. The status register is read-only. The enable register holds one global enable and one enable bit per peripheral source. Peripheral sources are enabled by a 1, and bank summaries are not masked here because masking for them happens inside each bank. The host request is registered. Whenever every enabled pending source goes away, the line drops for at least one cycle, so the next request gives a fresh rising edge that an edge-triggered host input can catch.

Top module: `intStatusAggregator`

## Requirements
- R1: Status bits 0 to 3 show the four GPIO bank summary inputs in bank order, with bank 0 at bit 0. They are readable in the same cycle when `regSel` is 0.
- R2: Status bits 4 to 9 show peripheral inputs 0 to 5 in ascending order. Status bits 10 to 15 always read as zero.
- R3: In the enable register, bit 0 is the global enable and bits 1 to 6 enable peripheral sources 0 to 5, where 1 means enabled. A write with `regSel` = 1 and `regWrEn` = 1 loads it at the clock edge. Bits 7 to 15 are discarded on write and read back as zero.
- R4: `hostIrq` is registered. In the cycle after an edge where the global enable is set and at least one qualifying status bit is set, it is high. In all other cases it is low.
- R5: While the global enable is 0, `hostIrq` stays low, whatever is pending.
- R6: A pending peripheral source whose enable bit is 0 still shows in the status register but does not raise `hostIrq`.
- R7: A pending bank summary bit raises `hostIrq` whenever the global enable is set, whatever the peripheral enable bits hold.
- R8: Reset clears the enable register and drives `hostIrq` low.
- R9: Once all qualifying pending bits clear, `hostIrq` falls one cycle later. A later request then gives a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankIrq | input | 4 | GPIO bank summary interrupt levels |
| periphIrq | input | 6 | Peripheral interrupt request levels |
| regSel | input | 1 | Register select: 0 status, 1 enable register |
| regWrEn | input | 1 | Write strobe (takes effect only for the enable register) |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for the selected register |
| hostIrq | output | 1 | Registered interrupt request to the host |

## Verification
The bench goes after the opposite mask senses. A design that treated peripheral enable bits as masks, or gated bank bits with them, would raise or drop `hostIrq` in the wrong rows of the table. It checks that `hostIrq` lags its inputs by exactly one edge: a combinational output would already be high in the same cycle the inputs change. It also checks that the line falls after an all-clear and rises again afterwards. A sticky output would never show that second rising edge. Finally, it writes ones to the unused enable bits, which a design keeping the full word would return on readback.

// File: rtl/intAggPkg.sv
package intAggPkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } regSelE;

  typedef struct packed {
    logic enableWr;
    logic rdEnable;
  } aggStrobeT;
endpackage

// File: rtl/intAggControl.sv
module intAggControl
  import intAggPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regSel,
  input  logic      regWrEn,
  input  logic      pendQual,
  output aggStrobeT strobes,
  output logic      hostIrq
);
  regSelE selE;

  always_comb begin
    selE = regSelE'(regSel);
    strobes.enableWr = regWrEn && (selE == SEL_ENABLE);
    strobes.rdEnable = (selE == SEL_ENABLE);
  end

  // Registered request: drops for at least one cycle after an all-clear.
  always_ff @(posedge clk) begin
    if (!rstN) hostIrq <= 1'b0;
    else       hostIrq <= pendQual;
  end
endmodule

// File: rtl/intAggDatapath.sv
module intAggDatapath
  import intAggPkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_BANKS-1:0]  bankIrq,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  aggStrobeT             strobes,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  pendQual
);
  localparam int STAT_W     = NUM_BANKS + NUM_PERIPH;
  localparam int EN_W       = NUM_PERIPH + 1;
  localparam int GLOBAL_BIT = 0;
  localparam int PEN_BASE   = 1;

  logic [EN_W-1:0]       enableQ;
  logic [STAT_W-1:0]     statusVec;
  logic [NUM_PERIPH-1:0] periphQual;

  always_ff @(posedge clk) begin
    if (!rstN)                 enableQ <= '0;
    else if (strobes.enableWr) enableQ <= wrData[EN_W-1:0];
  end

  assign statusVec = {periphIrq, bankIrq};

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_pgate
    assign periphQual[p] = periphIrq[p] & enableQ[PEN_BASE + p];
  end

  assign pendQual = enableQ[GLOBAL_BIT] & ((|bankIrq) | (|periphQual));

  always_comb begin
    if (strobes.rdEnable) rdData = {{(DATA_W-EN_W){1'b0}}, enableQ};
    else                  rdData = {{(DATA_W-STAT_W){1'b0}}, statusVec};
  end
endmodule

// File: rtl/intStatusAggregator.sv
module intStatusAggregator
  import intAggPkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_BANKS-1:0]  bankIrq,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  logic                  regSel,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  hostIrq
);
  aggStrobeT strobes;
  logic      pendQual;

  intAggControl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .pendQual(pendQual), .strobes(strobes), .hostIrq(hostIrq)
  );

  intAggDatapath #(
    .NUM_BANKS(NUM_BANKS), .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bankIrq(bankIrq), .periphIrq(periphIrq),
    .strobes(strobes), .wrData(regWrData), .rdData(regRdData),
    .pendQual(pendQual)
  );
endmodule

// File: rtl/intAggChecker.sv
module intAggChecker #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  parameter int DATA_W     = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_BANKS-1:0]  bankIrq,
  input logic [NUM_PERIPH-1:0] periphIrq,
  input logic                  regSel,
  input logic                  regWrEn,
  input logic [DATA_W-1:0]     regWrData,
  input logic [DATA_W-1:0]     regRdData,
  input logic                  hostIrq
);
  localparam int EN_W   = NUM_PERIPH + 1;
  localparam int STAT_W = NUM_BANKS + NUM_PERIPH;

  logic [EN_W-1:0] shadowEn;
  logic            expectIrq;

  always_ff @(posedge clk) begin
    if (!rstN)                   shadowEn <= '0;
    else if (regWrEn && regSel)  shadowEn <= regWrData[EN_W-1:0];
  end

  assign expectIrq = shadowEn[0] &
                     ((|bankIrq) | (|(periphIrq & shadowEn[EN_W-1:1])));

  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    expectIrq |=> hostIrq);

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !expectIrq |=> !hostIrq);

  // R5
  global_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shadowEn[0] |=> !hostIrq);

  // R1
  status_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> regRdData == {{(DATA_W-STAT_W){1'b0}}, periphIrq, bankIrq});

  // R3
  enable_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> regRdData == {{(DATA_W-EN_W){1'b0}}, shadowEn});
endmodule

bind intStatusAggregator intAggChecker #(
  .NUM_BANKS(NUM_BANKS), .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)
) chk (
  .clk(clk), .rstN(rstN), .bankIrq(bankIrq), .periphIrq(periphIrq),
  .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .hostIrq(hostIrq)
);

// File: tb/intStatusAggregator_test.sv
`timescale 1ns/1ps
module intStatusAggregator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  bankIrq = '0;
  logic [5:0]  periphIrq = '0;
  logic        regSel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        hostIrq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  intStatusAggregator uut (
    .clk(clk), .rstN(rstN), .bankIrq(bankIrq), .periphIrq(periphIrq),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .hostIrq(hostIrq)
  );

  // {bank[3:0], periph[5:0], enable[6:0], expected hostIrq}
  localparam int NVEC = 9;
  localparam logic [17:0] VECS [NVEC] = '{
    18'b0000_000000_0000001_0,  // R4 nothing pending
    18'b0001_000000_0000001_1,  // R7 bank 0 with global only
    18'b1000_000000_0000000_0,  // R5 global off
    18'b0000_000001_0000001_0,  // R6 periph 0 disabled
    18'b0000_000001_0000011_1,  // R4 periph 0 enabled
    18'b0000_100000_1000001_1,  // R4 periph 5 enabled
    18'b0000_100000_0111111_0,  // R6 periph 5 disabled
    18'b0100_011111_1111110_0,  // R5 global off, all enabled
    18'b0010_000000_0000001_1   // R7 bank 1
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeEnable(input logic [15:0] val);
    @(negedge clk);
    regSel = 1'b1; regWrEn = 1'b1; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8", {15'd0, hostIrq}, 16'd0);
    regSel = 1'b1; #0.5;
    chk("R8", regRdData, 16'h0000);
    regSel = 1'b0; #0.5;
    chk("R2", regRdData, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      writeEnable({9'd0, VECS[i][7:1]});
      bankIrq = VECS[i][17:14]; periphIrq = VECS[i][13:8];
      @(negedge clk);
      chk("R4", {15'd0, hostIrq}, {15'd0, VECS[i][0]});
      chk("R1", regRdData, {6'd0, VECS[i][13:8], VECS[i][17:14]});
      regSel = 1'b1; #0.5;
      chk("R3", regRdData, {9'd0, VECS[i][7:1]});
      regSel = 1'b0;
      bankIrq = '0; periphIrq = '0;
      @(negedge clk);
    end

    // R3 upper write bits discarded
    writeEnable(16'hFF81);
    regSel = 1'b1; #0.5;
    chk("R3", regRdData, 16'h0001);
    regSel = 1'b0;

    // R2 status upper bits zero with all inputs set
    bankIrq = 4'hF; periphIrq = 6'h3F; #0.5;
    chk("R2", regRdData, 16'h03FF);
    bankIrq = '0; periphIrq = '0;
    @(negedge clk);

    // R4 registered: no change in the same cycle as the input
    chk("R4", {15'd0, hostIrq}, 16'd0);
    periphIrq = 6'b000100; bankIrq = 4'b0100; #0.5;
    chk("R4", {15'd0, hostIrq}, 16'd0);
    @(negedge clk);
    chk("R4", {15'd0, hostIrq}, 16'd1);

    // R9 fall after all-clear, then a fresh rise
    bankIrq = '0; periphIrq = '0;
    @(negedge clk);
    chk("R9", {15'd0, hostIrq}, 16'd0);
    bankIrq = 4'b1000;
    @(negedge clk);
    chk("R9", {15'd0, hostIrq}, 16'd1);

    // R8 reset clears enable and output mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R8", {15'd0, hostIrq}, 16'd0);
    regSel = 1'b1; #0.5;
    chk("R8", regRdData, 16'h0000);
    regSel = 1'b0; bankIrq = '0;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule